// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave that lets an external controller program and inspect a small bank of 16-bit configuration registers. The controller pulls the enable line low, clocks in a 24-bit frame on the serial data input, and raises enable again. The first bit chooses between a read and a write, the next seven bits name a register, and the remaining sixteen bit slots carry the data word, most significant bit first in both fields.

On a write frame the slave collects the data word and commits it to the addressed register only once the last bit has arrived. On a read frame the slave turns the data-bit slots around and drives the register contents on its serial output. Each bit is launched after a falling serial clock edge, so the controller can capture it on the next rising edge. The output enable is asserted only during those sixteen slots, so the output can share one bidirectional data line with the input.

The serial lines are brought into the system clock domain through synchronizers and oversampled, so all state runs from one fast clock with a synchronous active-high reset. The serial clock must be several times slower than the system clock.

Top module: `sif_slave`

## Requirements
- R1: Synchronous reset loads register k (0 <= k < NUM_REGS) with {4'hA, k[3:0], 8'h3C}, drives sdo_o and sdo_oe_o low, and leaves every register readable at that value.
- R2: A write frame (first bit 0) with address bits A6..A0 and data bits D15..D0, all MSB first and sampled on rising serial clock edges, stores the data in the addressed register after the 24th bit.
- R3: A read frame (first bit 1) returns the addressed register as D15..D0 on sdo_o, each bit changing only after a falling serial clock edge and valid at the following rising edge.
- R4: sdo_oe_o is high only during the 16 data-bit slots of a read frame, and low during address slots, during whole write frames and after the frame's last falling edge.
- R5: Serial clock and data activity while the enable line is high changes no register and does not drive the output.
- R6: A write frame cut short by enable rising before the 24th bit leaves every register unchanged.
- R7: A read of an address at or above NUM_REGS returns all zeros, and a write to such an address modifies no register.
- R8: A read frame modifies no register, whatever is present on the data input during its data slots.
- R9: Reset in the middle of a frame clears the bit counter, so a frame that starts after reset is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the controller |
| sen_n_i | input | 1 | Active-low frame enable |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial read data output |
| sdo_oe_o | output | 1 | Output driver enable for a shared data line |

## Verification
Every serial edge reaches the core about three system cycles after the pin moves (two synchronizer stages plus the edge register), and a read bit appears on sdo_o one cycle later, so the bench holds each serial half period for eight system cycles and samples sdo_o and sdo_oe_o just before it raises the serial clock. A write lands in the register two system cycles after the synchronized 24th rising edge, well inside the closing half period, so its effect is checked by a following read frame. The driver queues the expected word for each complete read and the monitor compares it against the collected word as soon as the frame ends, while the enable checks are scored per frame.

// File: rtl/sif_pkg.sv
package sif_pkg;
  localparam int SIF_DW = 16;
  localparam int SIF_AW = 7;

  // Default contents of register idx after reset
  function automatic logic [SIF_DW-1:0] sif_reset_value(input int idx);
    logic [3:0] nib;
    nib = 4'(idx);
    return {4'hA, nib, 8'h3C};
  endfunction
endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) ff <= {STAGES{RST_VAL}};
    else     ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/sif_regbank.sv
module sif_regbank
  import sif_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DW       = SIF_DW,
  parameter int AW       = SIF_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [NUM_REGS-1:0][DW-1:0] regs;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[k] <= DW'(sif_reset_value(k));
      else if (wr_en && (int'(wr_addr) == k))
        regs[k] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) < NUM_REGS)
      rd_data = regs[rd_addr[IDX_W-1:0]];
  end

  // R2
  no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && !$past(rst)) |-> $stable(regs));

  // R7
  unimpl_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (int'(wr_addr) >= NUM_REGS)) |=> $stable(regs));
endmodule

// File: rtl/sif_frame.sv
module sif_frame
  import sif_pkg::*;
#(
  parameter int DW = SIF_DW,
  parameter int AW = SIF_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_s,
  input  logic          sen_s,
  input  logic          sdi_s,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sdo,
  output logic          sdo_oe
);
  localparam int HDR_BITS   = AW + 1;
  localparam int FRAME_BITS = HDR_BITS + DW;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] HDR_END   = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] FRM_LAST  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FRM_END   = CNT_W'(FRAME_BITS);

  logic             sclk_q;
  logic             rise, fall;
  logic [CNT_W-1:0] cnt;
  logic             rw_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    rx_sh;
  logic [DW-1:0]    tx_sh;

  assign rise    = sclk_s & ~sclk_q;
  assign fall    = ~sclk_s & sclk_q;
  assign rd_addr = {addr_q[AW-2:0], sdi_s};

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_s;
  end

  // Receive side: bit counter, header and data shift
  always_ff @(posedge clk) begin
    if (rst || sen_s) begin
      cnt    <= '0;
      rw_q   <= 1'b0;
      addr_q <= '0;
      rx_sh  <= '0;
    end else if (rise && (cnt < FRM_END)) begin
      cnt <= cnt + 1'b1;
      if (cnt == '0)            rw_q   <= sdi_s;
      else if (cnt < HDR_END)   addr_q <= {addr_q[AW-2:0], sdi_s};
      else                      rx_sh  <= {rx_sh[DW-2:0], sdi_s};
    end
  end

  // Write commit after the last bit of a write frame
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= !sen_s && rise && (cnt == FRM_LAST) && !rw_q;
      if (!sen_s && rise && (cnt == FRM_LAST)) begin
        wr_addr <= addr_q;
        wr_data <= {rx_sh[DW-2:0], sdi_s};
      end
    end
  end

  // Transmit side: load at last header bit, launch on falling edges
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh  <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (sen_s) begin
      sdo_oe <= 1'b0;
    end else begin
      if (rise && (cnt == HDR_LAST) && rw_q)
        tx_sh <= rd_data;
      if (fall && rw_q && (cnt >= HDR_END) && (cnt < FRM_END)) begin
        sdo    <= tx_sh[DW-1];
        tx_sh  <= {tx_sh[DW-2:0], 1'b0};
        sdo_oe <= 1'b1;
      end else if (fall && (cnt == FRM_END)) begin
        sdo_oe <= 1'b0;
      end
    end
  end

  // R4
  oe_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> (rw_q && (cnt == HDR_END)));

  // R4
  oe_gated_chk: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> !sen_s);

  // R3
  sdo_launch_chk: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(sdo));

  // R8
  read_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && rw_q) |=> !wr_en);
endmodule

// File: rtl/sif_slave.sv
module sif_slave
  import sif_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = SIF_DW,
  parameter int ADDR_W      = SIF_AW
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic sen_n_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic              sclk_s, sen_s, sdi_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en;

  sif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst(rst), .d(sclk_i), .q(sclk_s));
  sif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sen (
    .clk(clk), .rst(rst), .d(sen_n_i), .q(sen_s));
  sif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst(rst), .d(sdi_i), .q(sdi_s));

  sif_frame #(.DW(DATA_W), .AW(ADDR_W)) u_frame (
    .clk(clk), .rst(rst),
    .sclk_s(sclk_s), .sen_s(sen_s), .sdi_s(sdi_s),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(sdo_o), .sdo_oe(sdo_oe_o));

  sif_regbank #(.NUM_REGS(NUM_REGS), .DW(DATA_W), .AW(ADDR_W)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data));
endmodule

// File: tb/sif_slave_tb_top.sv
`timescale 1ns/1ps
module sif_slave_tb_top;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sen_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe;

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  logic [15:0] got_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  sif_slave dut_i (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sen_n_i(sen_n), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe));

  function automatic logic [15:0] dflt(input int k);
    return {4'hA, 4'(k), 8'h3C};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [15:0] g, e;
      string t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(g === e, t, g, e);
    end
  end

  task automatic frame(input logic rw, input logic [6:0] addr, input logic [15:0] data,
                       input int nbits, input logic [15:0] exp, input string tag);
    logic [23:0] word;
    logic [15:0] got;
    bit oe_ok;
    word = {rw, addr, data};
    got = '0;
    oe_ok = 1'b1;
    sen_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = word[23-i];
      repeat (HALF) @(negedge clk);
      if (rw && i >= 8) begin
        got = {got[14:0], sdo};
        if (sdo_oe !== 1'b1) oe_ok = 1'b0;
      end else if (sdo_oe !== 1'b0) oe_ok = 1'b0;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    if (sdo_oe !== 1'b0) oe_ok = 1'b0;
    sen_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
    check(oe_ok, "R4 output enable window", 16'(oe_ok), 16'h1);
    if (rw && nbits == 24) begin
      exp_q.push_back(exp);
      got_q.push_back(got);
      tag_q.push_back(tag);
    end
  endtask

  task automatic rd(input logic [6:0] addr, input logic [15:0] exp, input string tag);
    frame(1'b1, addr, 16'hC3A5, 24, exp, tag);
  endtask

  task automatic wr(input logic [6:0] addr, input logic [15:0] data, input int nbits);
    frame(1'b0, addr, data, nbits, 16'h0, "");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(sdo === 1'b0 && sdo_oe === 1'b0, "R1 outputs after reset",
          {14'h0, sdo, sdo_oe}, 16'h0);

    for (int k = 0; k < 8; k++) rd(7'(k), dflt(k), "R1 default value");

    wr(7'd3, 16'hBEEF, 24);
    rd(7'd3, 16'hBEEF, "R2 write then read");
    wr(7'd0, 16'h0001, 24);
    rd(7'd0, 16'h0001, "R3 LSB-only pattern");
    wr(7'd7, 16'h8000, 24);
    rd(7'd7, 16'h8000, "R3 MSB-only pattern");

    wr(7'd8, 16'hFFFF, 24);
    rd(7'd8, 16'h0000, "R7 unimplemented read");
    rd(7'd127, 16'h0000, "R7 top address read");
    rd(7'd0, 16'h0001, "R7 write to unimplemented kept reg0");

    wr(7'd4, 16'h1111, 23);
    rd(7'd4, dflt(4), "R6 23-bit write ignored");
    wr(7'd4, 16'h2222, 10);
    rd(7'd4, dflt(4), "R6 10-bit write ignored");

    rd(7'd3, 16'hBEEF, "R8 read with data on input");
    rd(7'd3, 16'hBEEF, "R8 register unchanged by read");

    // R5: clock a full write-looking frame with enable high
    begin
      logic [23:0] w;
      bit oe_quiet;
      w = {1'b0, 7'd2, 16'h5555};
      oe_quiet = 1'b1;
      for (int i = 0; i < 24; i++) begin
        sdi = w[23-i];
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
        if (sdo_oe !== 1'b0) oe_quiet = 1'b0;
      end
      repeat (2*HALF) @(negedge clk);
      check(oe_quiet, "R5 no drive while disabled", 16'(oe_quiet), 16'h1);
    end
    rd(7'd2, dflt(2), "R5 register untouched while disabled");

    // R9: reset mid-frame, enable kept low into the next frame
    wr(7'd5, 16'h1234, 24);
    sen_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      sdi = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (HALF) @(negedge clk);
    rd(7'd5, dflt(5), "R9 frame decoded after mid-frame reset");
    rd(7'd3, dflt(3), "R1 reset reloads default");

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule